// File: doc/BRIEF.md
# Seconds Counter With Alarm And Set/Clear Register Bank

This block is the core of a real-time clock. It counts pulses from an enable that comes from a crystal domain. Every N pulses it advances a 32-bit seconds count, and N is 32000 or 32768 depending on a divide-select bit. The block compares the count against a 32-bit alarm value. On a match it latches a sticky alarm flag, and from that flag it drives an interrupt line and a wake request.

Software reaches the block through a word-addressed register bank with single-cycle writes and combinational reads. The two control registers, the main control word and the persistent word, each have three write addresses. The base address loads the register. Base+0x4 ORs the written data into it, and base+0x8 clears every bit that is set in the data. One bit can therefore be changed without a read-modify-write. A read-only status word reports that the block is present and which crystal the pins detected.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset, the control word, the persistent word, the seconds count and the alarm value all read zero, and `irq` and `wake` are low.
- R2: The status word at 0x10 reads bit 31 as one, bit 28 as `det_alt`, bit 27 as `det_std` and all other bits as zero. Writes to it change nothing.
- R3: The control word is at 0x00, and only bits 0 (alarm irq enable), 1 (millisecond irq enable), 2 (alarm flag) and 4 (watchdog enable) are writable. The persistent word is at 0x60, and only bits 0, 1 (wake enable), 2 (alarm enable), 4, 5, 6 (divide select) and 7 (wake flag) are writable. A write at base loads the word, a write at base+0x4 ORs the data in, and a write at base+0x8 clears the bits set in the data. Bits that are not writable read zero.
- R4: The seconds count at 0x30 rises by one on the enable pulse that completes N pulses. N is DIV_ALT (default 32000) when persistent bit 6 is one and DIV_STD (default 32768) when it is zero.
- R5: A write to 0x30 loads the seconds count and restarts the prescaler, so the next increment needs a full N pulses.
- R6: The alarm value at 0x40 is a plain 32-bit read/write register.
- R7: While persistent bit 2 is one and the seconds count equals the alarm value, control bit 2 is one from the next clock on. It stays one until software clears it. When persistent bit 2 is zero, an equal count sets nothing.
- R8: When a match and a software clear of control bit 2 fall in the same cycle, the match wins.
- R9: `irq` equals control bit 2 AND control bit 0. `wake` equals control bit 2 AND persistent bit 1.
- R10: A match that occurs while persistent bit 1 is one also sets persistent bit 7 on the next clock. That bit stays set until software clears it.
- R11: The seconds count wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_en | input | 1 | One-cycle pulse per crystal period |
| det_alt | input | 1 | A 32000 Hz crystal is detected |
| det_std | input | 1 | A 32768 Hz crystal is detected |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Alarm wake request |

## Verification
The assertions assume that reset is held for at least one clock and that `bus_addr` and `bus_wr` are stable and known at every clock edge. They also assume that `xtal_en` is a single-cycle strobe in the core clock domain, so the seconds count never moves by more than one per clock. The stimulus drives every input on the falling edge. It pulses `xtal_en` for exactly one cycle with random gaps, and during the random register phase it keeps the alarm value far from the count, so that only directed phases produce matches.

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm #(
  parameter int DIV_ALT = 32000,
  parameter int DIV_STD = 32768,
  parameter int AW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xtal_en,
  input  logic          det_alt,
  input  logic          det_std,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          wake
);
  localparam int DMAX = (DIV_STD > DIV_ALT) ? DIV_STD : DIV_ALT;
  localparam int PW   = $clog2(DMAX) + 1;
  localparam int IW   = AW - 4;
  localparam logic [IW-1:0] IX_CTRL = IW'(0);
  localparam logic [IW-1:0] IX_STAT = IW'(1);
  localparam logic [IW-1:0] IX_SEC  = IW'(3);
  localparam logic [IW-1:0] IX_ALM  = IW'(4);
  localparam logic [IW-1:0] IX_PERS = IW'(6);
  localparam logic [31:0] CTRL_MASK = 32'h0000_0017;
  localparam logic [31:0] PERS_MASK = 32'h0000_00F7;
  localparam logic [PW-1:0] LIM_ALT = PW'(DIV_ALT - 1);
  localparam logic [PW-1:0] LIM_STD = PW'(DIV_STD - 1);

  logic [31:0]   ctrl_q, pers_q, sec_q, alarm_q;
  logic [31:0]   ctrl_d, pers_d;
  logic [PW-1:0] pre_q, pre_lim;
  logic [IW-1:0] idx;
  logic [1:0]    kind;
  logic          aligned, hit;

  assign idx     = bus_addr[AW-1:4];
  assign kind    = bus_addr[3:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign hit     = pers_q[2] && (sec_q == alarm_q);
  assign pre_lim = pers_q[6] ? LIM_ALT : LIM_STD;
  assign irq     = ctrl_q[2] & ctrl_q[0];
  assign wake    = ctrl_q[2] & pers_q[1];

  function automatic logic [31:0] apply(input logic [31:0] old, input logic [31:0] wd,
                                        input logic [1:0] k, input logic [31:0] m);
    case (k)
      2'd0:    apply = wd & m;
      2'd1:    apply = (old | wd) & m;
      2'd2:    apply = old & ~wd;
      default: apply = old;
    endcase
  endfunction

  always_comb begin
    ctrl_d = ctrl_q;
    pers_d = pers_q;
    if (bus_wr && aligned && idx == IX_CTRL) ctrl_d = apply(ctrl_q, bus_wdata, kind, CTRL_MASK);
    if (bus_wr && aligned && idx == IX_PERS) pers_d = apply(pers_q, bus_wdata, kind, PERS_MASK);
    if (hit) begin
      ctrl_d[2] = 1'b1;
      if (pers_q[1]) pers_d[7] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pers_q  <= '0;
      sec_q   <= '0;
      alarm_q <= '0;
      pre_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      pers_q <= pers_d;
      if (bus_wr && aligned && idx == IX_ALM && kind == 2'd0) alarm_q <= bus_wdata;
      if (bus_wr && aligned && idx == IX_SEC && kind == 2'd0) begin
        sec_q <= bus_wdata;
        pre_q <= '0;
      end else if (xtal_en) begin
        if (pre_q >= pre_lim) begin
          pre_q <= '0;
          sec_q <= sec_q + 32'd1;
        end else begin
          pre_q <= pre_q + PW'(1);
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned && kind != 2'd3) begin
      case (idx)
        IX_CTRL: bus_rdata = ctrl_q;
        IX_STAT: bus_rdata = {1'b1, 2'b00, det_alt, det_std, 27'd0};
        IX_SEC:  bus_rdata = sec_q;
        IX_ALM:  bus_rdata = alarm_q;
        IX_PERS: bus_rdata = pers_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk #(parameter int AW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic [31:0]   ctrl_q,
  input logic [31:0]   pers_q,
  input logic [31:0]   sec_q,
  input logic [31:0]   alarm_q
);
  logic ctrl_sw, sec_sw, match;
  assign ctrl_sw = bus_wr && (bus_addr == AW'(8'h00) || bus_addr == AW'(8'h08));
  assign sec_sw  = bus_wr && (bus_addr == AW'(8'h30));
  assign match   = pers_q[2] && (sec_q == alarm_q);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_q[2]) && !$past(ctrl_sw) |-> ctrl_q[2]);
  // R7
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[2]) |-> $past(match) || $past(bus_wr && (bus_addr == AW'(8'h00) || bus_addr == AW'(8'h04))));
  // R8
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(match) |-> ctrl_q[2]);
  // R4
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sec_sw) && !$stable(sec_q) |-> sec_q == $past(sec_q) + 32'd1);
  // R5
  sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sec_sw) |-> sec_q == $past(bus_wdata));
  // R2
  present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == AW'(8'h10) |-> bus_rdata[31] && bus_rdata[26:0] == 27'd0);
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_q(ctrl_q),
  .pers_q(pers_q), .sec_q(sec_q), .alarm_q(alarm_q)
);

// File: tb/sim_rtc_sec_alarm.sv
`timescale 1ns/1ps
module sim_rtc_sec_alarm;
  localparam int NA = 5;
  localparam int NS = 7;
  logic clk = 0, rst_n = 0, xtal_en = 0, det_alt = 0, det_std = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, wake;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  rtc_sec_alarm #(.DIV_ALT(NA), .DIV_STD(NS), .AW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .det_alt(det_alt), .det_std(det_std),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wake(wake));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xtal_en = 1;
      @(negedge clk); xtal_en = 0;
      repeat ($urandom % 3) @(negedge clk);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] old, input logic [31:0] d,
                                        input int k, input logic [31:0] m);
    if (k == 0) return d & m;
    if (k == 1) return (old | d) & m;
    return old & ~d;
  endfunction

  initial begin
    #(200000 * 20);
    errs++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, cm, pm, s0;
    int k, n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h60, v); chk("R1 pers", v, 0);
    rd(8'h30, v); chk("R1 sec", v, 0);
    rd(8'h40, v); chk("R1 alarm", v, 0);
    chk("R1 irq/wake", {30'd0, irq, wake}, 0);
    // R2
    for (int i = 0; i < 4; i++) begin
      det_alt = i[0]; det_std = i[1];
      rd(8'h10, v); chk("R2 status", v, {1'b1, 2'b0, i[0], i[1], 27'd0});
    end
    wr(8'h10, 32'h0);
    rd(8'h10, v); chk("R2 write ignored", v, {1'b1, 2'b0, 1'b1, 1'b1, 27'd0});
    // R6
    wr(8'h40, 32'hA5C3_0F96); rd(8'h40, v); chk("R6 alarm rw", v, 32'hA5C3_0F96);
    // R3 random alias writes, no match possible
    wr(8'h40, 32'hFFFF_0000); wr(8'h30, 32'd0);
    cm = 0; pm = 0;
    for (int i = 0; i < 60; i++) begin
      k = $urandom % 3; v = $urandom;
      if ($urandom % 2) begin
        wr(8'(k * 4), v); cm = model(cm, v, k, 32'h17);
      end else begin
        wr(8'(8'h60 + k * 4), v); pm = model(pm, v, k, 32'hF7);
      end
      rd(8'h00, s0); chk("R3 ctrl", s0, cm);
      rd(8'h60, s0); chk("R3 pers", s0, pm);
      // R9
      chk("R9 irq", {31'd0, irq}, {31'd0, cm[2] & cm[0]});
      chk("R9 wake", {31'd0, wake}, {31'd0, cm[2] & pm[1]});
    end
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h68, 32'hFFFF_FFFF);
    // R4 standard divide
    wr(8'h30, 32'd10);
    pulse(NS - 1); rd(8'h30, v); chk("R4 std before", v, 10);
    pulse(1);      rd(8'h30, v); chk("R4 std step", v, 11);
    // R5 reload restarts prescaler
    pulse(3); wr(8'h30, 32'd50);
    pulse(NS - 1); rd(8'h30, v); chk("R5 no early step", v, 50);
    pulse(1);      rd(8'h30, v); chk("R5 full period", v, 51);
    // R4 random runs with either divide
    for (int i = 0; i < 8; i++) begin
      k = $urandom % 2;
      if (k) wr(8'h64, 32'h40); else wr(8'h68, 32'h40);
      s0 = $urandom; wr(8'h30, s0);
      n = $urandom % 25;
      pulse(n);
      rd(8'h30, v); chk("R4 random", v, s0 + 32'(n / (k ? NA : NS)));
    end
    // R11
    wr(8'h68, 32'h40); wr(8'h30, 32'hFFFF_FFFF);
    pulse(NS); rd(8'h30, v); chk("R11 wrap", v, 0);
    // R7 disabled alarm does not set flag
    wr(8'h40, 32'd100); wr(8'h30, 32'd100);
    @(negedge clk); rd(8'h00, v); chk("R7 no flag when disabled", v & 32'h4, 0);
    // R7/R10 match with wake enabled
    wr(8'h04, 32'h1); wr(8'h64, 32'h6);
    @(negedge clk);
    rd(8'h00, v); chk("R7 flag set", v & 32'h4, 32'h4);
    rd(8'h60, v); chk("R10 wake flag", v & 32'h80, 32'h80);
    chk("R9 irq on", {31'd0, irq}, 1);
    chk("R9 wake on", {31'd0, wake}, 1);
    // R8 clear during match loses
    wr(8'h08, 32'h4); rd(8'h00, v); chk("R8 hw wins", v & 32'h4, 32'h4);
    // R7 sticky after leaving match, then cleared
    wr(8'h30, 32'd7); @(negedge clk);
    rd(8'h00, v); chk("R7 sticky", v & 32'h4, 32'h4);
    wr(8'h08, 32'h4); rd(8'h00, v); chk("R7 clear", v & 32'h4, 0);
    chk("R9 irq off", {31'd0, irq}, 0);
    rd(8'h60, v); chk("R10 wake flag sticky", v & 32'h80, 32'h80);
    wr(8'h68, 32'h80); rd(8'h60, v); chk("R10 wake flag clear", v & 32'h80, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule